// File: doc/BRIEF.md
# Timer Compare with Event Trigger

The block pairs a free-running up-counter with a compare register. In event-trigger mode, the counter reaching the compare value raises a sticky compare flag at once. It can also issue a one-clock request to start an analog-to-digital conversion. It then arms a counter clear, which takes effect on the next enabled tick. The compare register therefore sets the counter period. With a compare value of C and the tick enable held high, the counter runs 0 to C, so one period is C+1 ticks.

The counter advances only on clock cycles where the tick enable is high. The armed clear replaces the increment on the first enabled tick at or after the match cycle. A write to the compare register while the clear is armed cancels the clear, and the counter keeps going. This lets software move the next event earlier or later. A match-driven clear never counts as a rollover: the overflow flag records only a genuine wrap from all-ones to zero. The block drives no output pin. It works only while its clock runs, so it does nothing while the clock is stopped for sleep.

Top module: `tce_timer_compare`

## Requirements
- R1: After a synchronous reset, the counter, the compare register, both flags and the conversion request are all zero.
- R2: When no clear is armed, the counter increases by one on each clock with `tick_en` high and holds its value on each clock with `tick_en` low.
- R3: The overflow flag sets on the clock where an enabled tick takes the counter from all-ones to zero. A match-driven clear, including one from the all-ones value, never sets the overflow flag.
- R4: Event behaviour (flag, conversion request, counter clear) happens only while `mode` equals 4'b1011. With any other value, the counter counts straight past the compare value.
- R5: In event mode, a cycle in which the counter equals the compare register sets `cmp_flag`, and the flag is visible one clock later.
- R6: `conv_start` is a one-clock pulse issued together with the flag set for each match event, and only when `adc_en` is high. It does not repeat while the counter stays equal to the compare value.
- R7: After a match, the first enabled tick loads zero into the counter in place of an increment. With `tick_en` held high and compare value C, events occur every C+1 clocks.
- R8: A compare-register write in the window between a match and the armed clear cancels the clear, and that tick increments the counter.
- R9: Both flags are sticky and are cleared only by their own one-clock clear strobes. A set in the same clock as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Counter advance enable for this clock |
| mode | input | 4 | Compare mode field; 4'b1011 selects event trigger |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | 16 | Compare register write value |
| adc_en | input | 1 | Allows the conversion request |
| cmp_flag_clr | input | 1 | Clear strobe for the compare flag |
| ovf_flag_clr | input | 1 | Clear strobe for the overflow flag |
| tmr_val | output | 16 | Current counter value |
| cmp_flag | output | 1 | Sticky compare-event flag |
| ovf_flag | output | 1 | Sticky counter-rollover flag |
| conv_start | output | 1 | One-clock conversion start request |

## Verification
The assertions assume that every input is a registered, glitch-free level sampled at the rising edge. They also assume that the clear strobes and compare writes are single-clock pulses, and that any mode change is visible in the cycle before the flag it gates. The bench changes every input just after the falling edge. It drops the strobes back to zero after each clock, and it changes the mode only between phases. It writes the compare register deliberately both while a clear is armed and from a distance. The bench therefore exercises the cancel window inside these assumptions and never creates a case the properties do not cover.

// File: rtl/tce_pkg.sv
package tce_pkg;

    // action applied to the counter on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_INC  = 2'd1,
        ACT_ZERO = 2'd2
    } tmr_act_e;

    // per-cycle event decisions
    typedef struct packed {
        logic     match;
        logic     evt;
        tmr_act_e act;
    } evt_ctl_t;

    function automatic logic mode_hit(input logic [3:0] mode, input logic [3:0] code);
        return mode == code;
    endfunction

endpackage

// File: rtl/tce_counter.sv
module tce_counter
    import tce_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  tmr_act_e     act,
    output logic [W-1:0] cnt,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case (act)
                ACT_INC:  cnt <= cnt + 1'b1;
                ACT_ZERO: cnt <= '0;
                default:  cnt <= cnt;
            endcase
        end
    end

    assign wrap = (act == ACT_INC) && (cnt == CNT_MAX);

    p_zero_load_r7: assert property (@(posedge clk) disable iff (rst)
        act == ACT_ZERO |=> cnt == '0);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        act == ACT_HOLD |=> $stable(cnt));

endmodule

// File: rtl/tce_evt_ctrl.sv
module tce_evt_ctrl
    import tce_pkg::*;
#(
    parameter int          W        = 16,
    parameter int          MW       = 4,
    parameter logic [MW-1:0] EVT_CODE = 4'b1011
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [MW-1:0] mode,
    input  logic [W-1:0]  tmr,
    input  logic [W-1:0]  cmp,
    input  logic          tick,
    input  logic          cmp_wr,
    output evt_ctl_t      ctl
);
    logic in_mode;
    logic seen_q;
    logic pend_q;
    logic zero_now;

    assign in_mode   = mode_hit(mode, EVT_CODE);
    assign ctl.match = in_mode && (tmr == cmp);
    assign ctl.evt   = ctl.match && !seen_q;
    assign zero_now  = in_mode && tick && (ctl.evt || pend_q) && !cmp_wr;
    assign ctl.act   = zero_now ? ACT_ZERO : (tick ? ACT_INC : ACT_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            // equality stays "seen" until the clear re-opens it
            seen_q <= ctl.match && !zero_now;
            if (!in_mode || zero_now || cmp_wr)
                pend_q <= 1'b0;
            else if (ctl.evt)
                pend_q <= 1'b1;
        end
    end

    p_zero_in_mode_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.act == ACT_ZERO |-> in_mode && tick);

    p_cancel_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && tick) |-> ctl.act == ACT_INC);

endmodule

// File: rtl/tce_sticky.sv
module tce_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)      q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

    p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        set |=> q);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !q);

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!clr && !set) |=> q == $past(q));

endmodule

// File: rtl/tce_timer_compare.sv
module tce_timer_compare
    import tce_pkg::*;
#(
    parameter int            W         = 16,
    parameter int            MW        = 4,
    parameter logic [MW-1:0] EVT_CODE  = 4'b1011,
    parameter bit            TRIG_CHAN = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic [MW-1:0] mode,
    input  logic          cmp_wr,
    input  logic [W-1:0]  cmp_wdata,
    input  logic          adc_en,
    input  logic          cmp_flag_clr,
    input  logic          ovf_flag_clr,
    output logic [W-1:0]  tmr_val,
    output logic          cmp_flag,
    output logic          ovf_flag,
    output logic          conv_start
);
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    logic [W-1:0] cmp_q;
    logic         wrap;
    evt_ctl_t     ctl;

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    tce_evt_ctrl #(.W(W), .MW(MW), .EVT_CODE(EVT_CODE)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .tmr    (tmr_val),
        .cmp    (cmp_q),
        .tick   (tick_en),
        .cmp_wr (cmp_wr),
        .ctl    (ctl)
    );

    tce_counter #(.W(W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .act  (ctl.act),
        .cnt  (tmr_val),
        .wrap (wrap)
    );

    tce_sticky u_cmp_flag (
        .clk (clk), .rst (rst), .set (ctl.evt), .clr (cmp_flag_clr), .q (cmp_flag)
    );

    tce_sticky u_ovf_flag (
        .clk (clk), .rst (rst), .set (wrap), .clr (ovf_flag_clr), .q (ovf_flag)
    );

    generate
        if (TRIG_CHAN) begin : g_trig
            logic conv_q;
            always_ff @(posedge clk) begin
                if (rst) conv_q <= 1'b0;
                else     conv_q <= ctl.evt && adc_en;
            end
            assign conv_start = conv_q;
        end else begin : g_no_trig
            assign conv_start = 1'b0;
        end
    endgenerate

    p_ovf_rollover_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(tmr_val) == TOP_VAL && tmr_val == '0);

    p_flag_mode_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(cmp_flag) |-> $past(mode) == EVT_CODE && $past(tmr_val) == $past(cmp_q));

    p_conv_gate_r6: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(adc_en) && cmp_flag);

endmodule

// File: tb/test_tce_timer_compare.sv
module test_tce_timer_compare;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, tick_en, cmp_wr, adc_en, cmp_flag_clr, ovf_flag_clr;
    logic [3:0]  mode;
    logic [15:0] cmp_wdata;
    logic [15:0] tmr_val;
    logic        cmp_flag, ovf_flag, conv_start;

    tce_timer_compare i_tce_timer_compare (
        .clk(clk), .rst(rst), .tick_en(tick_en), .mode(mode), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .adc_en(adc_en), .cmp_flag_clr(cmp_flag_clr),
        .ovf_flag_clr(ovf_flag_clr), .tmr_val(tmr_val), .cmp_flag(cmp_flag),
        .ovf_flag(ovf_flag), .conv_start(conv_start)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string ph = "R1";

    // behavioural reference
    int m_tmr, m_cmp;
    bit m_cf, m_of, m_cs, m_armed_seen, m_due;

    always @(posedge clk) begin : ref_model
        bit active, eq, fire, clear_now;
        cycles++;
        if (rst) begin
            m_tmr = 0; m_cmp = 0; m_cf = 0; m_of = 0; m_cs = 0;
            m_armed_seen = 0; m_due = 0;
        end else begin
            active    = (mode == 4'hB);
            eq        = active && (m_tmr == m_cmp);
            fire      = eq && !m_armed_seen;
            clear_now = active && tick_en && (fire || m_due) && !cmp_wr;
            if (fire) m_cf = 1; else if (cmp_flag_clr) m_cf = 0;
            if (tick_en && !clear_now && m_tmr == 16'hFFFF) m_of = 1;
            else if (ovf_flag_clr) m_of = 0;
            m_cs = fire && adc_en;
            if (!active || clear_now || cmp_wr) m_due = 0;
            else if (fire) m_due = 1;
            m_armed_seen = eq && !clear_now;
            if (clear_now) m_tmr = 0;
            else if (tick_en) m_tmr = (m_tmr + 1) & 16'hFFFF;
            if (cmp_wr) m_cmp = cmp_wdata;
        end
    end

    task automatic chk(bit ok, string tag, string what, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        chk(tmr_val == m_tmr[15:0], ph, "tmr_val", tmr_val, m_tmr);
        chk(cmp_flag == m_cf, ph, "cmp_flag", cmp_flag, m_cf);
        chk(ovf_flag == m_of, ph, "ovf_flag", ovf_flag, m_of);
        chk(conv_start == m_cs, ph, "conv_start", conv_start, m_cs);
        cmp_wr = 0; cmp_flag_clr = 0; ovf_flag_clr = 0;
    endtask

    task automatic run_until(logic [15:0] v, int lim);
        while (tmr_val != v && lim > 0) begin
            step();
            lim--;
        end
    endtask

    always @(posedge clk) begin
        if (cycles > 190000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1; tick_en = 0; mode = 0; cmp_wr = 0; cmp_wdata = 0;
        adc_en = 0; cmp_flag_clr = 0; ovf_flag_clr = 0;
        repeat (3) step();
        rst = 0;
        // R1 reset state
        chk(tmr_val == 0 && cmp_flag == 0 && ovf_flag == 0 && conv_start == 0,
            "R1", "reset outputs", {tmr_val, cmp_flag, ovf_flag, conv_start}, 0);

        // R2 irregular ticking
        ph = "R2";
        for (int i = 0; i < 40; i++) begin
            tick_en = 1'($urandom_range(0, 1));
            step();
        end

        // R5 / R7 first event, compare 60
        ph = "R5";
        mode = 4'hB; adc_en = 1; tick_en = 1;
        cmp_wr = 1; cmp_wdata = 16'd60;
        step();
        run_until(16'd60, 200);
        step();
        chk(tmr_val == 0, "R7", "cleared after match", tmr_val, 0);
        chk(cmp_flag == 1, "R5", "flag after match", cmp_flag, 1);
        chk(conv_start == 1, "R6", "conv pulse", conv_start, 1);

        // R7 period C+1
        ph = "R7";
        n = 0;
        do begin step(); n++; end while (!conv_start && n < 200);
        chk(n == 61, "R7", "period clocks", n, 61);

        // R9 clear, then set beats clear
        ph = "R9";
        cmp_flag_clr = 1;
        step();
        chk(cmp_flag == 0, "R9", "flag cleared", cmp_flag, 0);
        run_until(16'd60, 200);
        cmp_flag_clr = 1;
        step();
        chk(cmp_flag == 1, "R9", "set wins over clear", cmp_flag, 1);

        // R6 no retrigger while equal
        ph = "R6";
        run_until(16'd60, 200);
        tick_en = 0;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            step();
            if (conv_start) n++;
        end
        chk(n == 1, "R6", "pulses while held equal", n, 1);
        chk(tmr_val == 60, "R6", "held value", tmr_val, 60);

        // R8 write in the window cancels the clear
        ph = "R8";
        cmp_wr = 1; cmp_wdata = 16'd100; tick_en = 1;
        step();
        chk(tmr_val == 61, "R8", "counted on instead of clear", tmr_val, 61);
        run_until(16'd100, 200);
        step();
        chk(tmr_val == 0, "R8", "next event at new value", tmr_val, 0);

        // R4 other mode ignores the compare value
        ph = "R4";
        mode = 4'hA; cmp_flag_clr = 1;
        step();
        repeat (150) step();
        chk(tmr_val == 151, "R4", "counted past compare", tmr_val, 151);
        chk(cmp_flag == 0, "R4", "no flag outside mode", cmp_flag, 0);

        // R6 event with conversion disabled
        ph = "R6";
        mode = 4'hB; adc_en = 0; cmp_wr = 1; cmp_wdata = 16'd200;
        step();
        run_until(16'd200, 300);
        step();
        chk(conv_start == 0, "R6", "no pulse when adc off", conv_start, 0);
        chk(cmp_flag == 1, "R5", "flag still set", cmp_flag, 1);

        // R3 clear from all-ones is not an overflow
        ph = "R3";
        adc_en = 1; cmp_wr = 1; cmp_wdata = 16'hFFFF;
        step();
        run_until(16'hFFFF, 70000);
        step();
        chk(tmr_val == 0, "R3", "match clear from top", tmr_val, 0);
        chk(ovf_flag == 0, "R3", "no ovf on match clear", ovf_flag, 0);

        // R3 genuine rollover, with R9 clear in same clock
        mode = 4'h0;
        run_until(16'hFFFF, 70000);
        ovf_flag_clr = 1;
        step();
        chk(ovf_flag == 1, "R3", "ovf on rollover", ovf_flag, 1);
        chk(tmr_val == 0, "R3", "rolled to zero", tmr_val, 0);
        ph = "R9";
        ovf_flag_clr = 1;
        step();
        chk(ovf_flag == 0, "R9", "ovf cleared", ovf_flag, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule